// File: doc/BRIEF.md
# Serial-In Parallel-Out Register with Output Latch

The block collects a serial bit stream in a chain of flip-flops and, on request, copies the whole chain into a separate output latch that drives the parallel outputs. Two independent clocks serve the two banks. The shift clock advances the chain. The store clock snapshots the chain into the outputs. Because of this split, the outputs keep a stable word on display while the next word is being shifted in.

Each bank has its own asynchronous active-low clear. A serial output taken from the final chain stage carries bits on to the next block, so several blocks can be chained into a longer register. Because these clears are functional inputs with a defined asynchronous action, they act at once and do not wait for a clock edge. The width is a parameter with a default of 8.

Top module: `sipo_store_reg`

## Requirements
- R1: On a rising edge of `shift_clk`, chain stage 0 takes `ser_in` and every stage i>0 takes the value that stage i-1 held before the edge. Stage 0 is `par_q[0]` after a store and the last stage is `par_q[WIDTH-1]`. Loading a word MSB first with WIDTH shifts therefore places it in `par_q` unchanged.
- R2: A falling edge of `shift_clk` leaves the chain unchanged, even when `ser_in` differs from its value at the preceding rising edge.
- R3: A rising edge of `store_clk` copies all chain stages into `par_q`. Between store edges `par_q` holds its value while the chain shifts.
- R4: A falling edge of `store_clk` leaves `par_q` unchanged.
- R5: A low `shift_clr_n` forces every chain stage to 0 at once, with no clock edge needed, and leaves `par_q` untouched.
- R6: A low `store_clr_n` forces `par_q` to 0 at once, with no clock edge needed, and leaves the chain untouched.
- R7: `ser_out` always equals the last chain stage. It changes only through `shift_clk` or `shift_clr_n` and never through the store clock or store clear.
- R8: When both clocks are driven by one signal, every edge stores the chain as it stood before that same edge, so `par_q` trails the chain by exactly one pulse.
- R9: Rising clock edges that arrive while a bank's clear is held low have no effect on that bank. After the clear is released, the bank follows its first rising clock edge normally.
- R10: When `ser_out` of one block feeds `ser_in` of a second block on shared clocks, the pair behaves as one register of twice the width. The second block holds the earlier-shifted (upper) half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Rising-edge clock for the shift chain |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| ser_in | input | 1 | Serial data into chain stage 0 |
| store_clk | input | 1 | Rising-edge clock that copies the chain into the output latch |
| store_clr_n | input | 1 | Asynchronous active-low clear of the output latch |
| par_q | output | WIDTH | Parallel outputs from the output latch |
| ser_out | output | 1 | Last chain stage, used for cascading |

## Verification
The bench builds two instances at the default width of 8. The second instance is fed from the first one's `ser_out`, so the 16-bit cascade of R10 can be observed at the ports of both blocks. With the 8-bit width, a table of byte patterns walks every stage through both values. The same width keeps the one-pulse lag and the clear isolation short enough to predict bit by bit.

// File: rtl/sipo_pkg.sv
// Package: shared constants for the serial-in parallel-out register.
// Assumes: every module of the block takes its default width from here.
package sipo_pkg;
    localparam int SIPO_WIDTH_DEFAULT = 8;
endpackage

// File: rtl/sipo_shift_bank.sv
// Module: chain of WIDTH flip-flops advanced by its own clock.
// Stage 0 takes the serial input. Each later stage takes its neighbour.
// Assumes: clr_n is an asynchronous active-low clear, released while
// clk is low.
module sipo_shift_bank #(
    parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             din,
    output logic [WIDTH-1:0] stages
);
    localparam int LAST = WIDTH - 1;

    // next value presented to each stage
    logic [WIDTH-1:0] feed;

    // Purpose: route the serial input to stage 0 and each stage to the next.
    always_comb begin
        feed = {stages[LAST-1:0], din};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        // Purpose: one chain stage with an asynchronous clear.
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                stages[i] <= 1'b0;
            end else begin
                stages[i] <= feed[i];
            end
        end
    end
endmodule

// File: rtl/sipo_hold_bank.sv
// Module: output latch bank that snapshots the chain on its own clock.
// Assumes: snap is stable at the edge. When this clock is tied to the
// chain clock, nonblocking update order makes it sample the pre-edge
// chain value.
module sipo_hold_bank #(
    parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] snap,
    output logic [WIDTH-1:0] held
);
    // Purpose: copy the chain into the output latch, clear asynchronously.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            held <= '0;
        end else begin
            held <= snap;
        end
    end
endmodule

// File: rtl/sipo_store_reg.sv
// Module: top of the serial-in parallel-out register with output latch.
// It joins the shift chain and the output latch and taps the last stage
// for cascading.
// Assumes: the two clock domains are independent. The store clock must
// follow the shift clock by enough margin when fresh chain data is wanted.
module sipo_store_reg #(
    parameter int WIDTH = sipo_pkg::SIPO_WIDTH_DEFAULT
) (
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             ser_in,
    input  logic             store_clk,
    input  logic             store_clr_n,
    output logic [WIDTH-1:0] par_q,
    output logic             ser_out
);
    logic [WIDTH-1:0] shift_q;

    sipo_shift_bank #(.WIDTH(WIDTH)) u_shift (
        .clk    (shift_clk),
        .clr_n  (shift_clr_n),
        .din    (ser_in),
        .stages (shift_q)
    );

    sipo_hold_bank #(.WIDTH(WIDTH)) u_hold (
        .clk   (store_clk),
        .clr_n (store_clr_n),
        .snap  (shift_q),
        .held  (par_q)
    );

    // Purpose: cascade tap from the last chain stage.
    always_comb begin
        ser_out = shift_q[WIDTH-1];
    end
endmodule

// File: rtl/sipo_store_reg_chk.sv
// Module: assertion checker bound to sipo_store_reg.
// Assumes: each clear is pulsed before the first edge of its clock.
module sipo_store_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             shift_clk,
    input logic             shift_clr_n,
    input logic             ser_in,
    input logic             store_clk,
    input logic             store_clr_n,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] par_q,
    input logic             ser_out
);
    // set by a clear, dropped on the next clock edge of that domain
    logic sh_clr_seen;
    logic st_clr_seen;

    // Purpose: remember a chain clear since the last shift edge.
    always_ff @(posedge shift_clk or negedge shift_clr_n) begin
        if (!shift_clr_n) sh_clr_seen <= 1'b1;
        else              sh_clr_seen <= 1'b0;
    end

    // Purpose: remember a latch clear since the last store edge.
    always_ff @(posedge store_clk or negedge store_clr_n) begin
        if (!store_clr_n) st_clr_seen <= 1'b1;
        else              st_clr_seen <= 1'b0;
    end

    // R1
    chain_advance_chk: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        (sh_clr_seen == 1'b0) |-> (shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)}));

    // R3
    store_copy_chk: assert property (@(posedge store_clk) disable iff (!store_clr_n)
        (st_clr_seen == 1'b0) |-> (par_q == $past(shift_q)));

    // R6
    latch_clear_chk: assert property (@(posedge shift_clk) disable iff (!shift_clr_n)
        (!store_clr_n) |-> (par_q == '0));

    // R5
    chain_clear_chk: assert property (@(posedge store_clk) disable iff (!store_clr_n)
        (!shift_clr_n) |-> (ser_out == 1'b0));
endmodule

bind sipo_store_reg sipo_store_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .shift_clk   (shift_clk),
    .shift_clr_n (shift_clr_n),
    .ser_in      (ser_in),
    .store_clk   (store_clk),
    .store_clr_n (store_clr_n),
    .shift_q     (shift_q),
    .par_q       (par_q),
    .ser_out     (ser_out)
);

// File: tb/tb_sipo_store_reg.sv
module tb_sipo_store_reg;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = CLK_PERIOD / 2;
    localparam int W = 8;
    localparam int WDOG_CYCLES = 20000;
    localparam int NVEC = 6;
    // {data byte, expected ser_out after loading it}
    localparam logic [8:0] VEC [NVEC] = '{
        {8'hA5, 1'b1}, {8'h3C, 1'b0}, {8'hFF, 1'b1},
        {8'h00, 1'b0}, {8'h81, 1'b1}, {8'h5A, 1'b0}
    };

    logic clk = 1'b0;
    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic shift_clr_n = 1'b1;
    logic store_clr_n = 1'b1;
    logic ser_in = 1'b0;
    logic [W-1:0] par_q, par_q2;
    logic ser_out, ser_out2;
    int n_checks = 0;
    int n_errors = 0;

    sipo_store_reg #(.WIDTH(W)) dut (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(ser_in),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_q(par_q), .ser_out(ser_out)
    );

    sipo_store_reg #(.WIDTH(W)) dut2 (
        .shift_clk(shift_clk), .shift_clr_n(shift_clr_n), .ser_in(ser_out),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_q(par_q2), .ser_out(ser_out2)
    );

    always #HALF clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        #HALF shift_clk = 1'b1;
        #HALF shift_clk = 1'b0;
    endtask

    task automatic store_pulse();
        #HALF store_clk = 1'b1;
        #HALF store_clk = 1'b0;
    endtask

    task automatic both_pulse(input logic b);
        ser_in = b;
        #HALF begin shift_clk = 1'b1; store_clk = 1'b1; end
        #HALF begin shift_clk = 1'b0; store_clk = 1'b0; end
    endtask

    task automatic load_byte(input logic [W-1:0] d);
        for (int i = W - 1; i >= 0; i--) shift_bit(d[i]);
    endtask

    task automatic clear_both();
        #1 begin shift_clr_n = 1'b0; store_clr_n = 1'b0; end
        #HALF begin shift_clr_n = 1'b1; store_clr_n = 1'b1; end
        #1;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [W-1:0] prev, m_sh, m_par, pat;
        logic [15:0] word;
        clear_both();
        // reset state: R5, R6
        check("R6 reset par_q", 32'(par_q), 32'h0);
        check("R5 reset ser_out", 32'(ser_out), 32'h0);

        // table walk: R1, R3, R7
        for (int v = 0; v < NVEC; v++) begin
            prev = par_q;
            load_byte(VEC[v][8:1]);
            check("R3 par_q held while shifting", 32'(par_q), 32'(prev));
            check("R7 ser_out last stage", 32'(ser_out), 32'(VEC[v][0]));
            store_pulse();
            check("R1 loaded byte", 32'(par_q), 32'(VEC[v][8:1]));
        end

        // R5: chain clear leaves latch alone
        load_byte(8'hC3);
        store_pulse();
        #1 shift_clr_n = 1'b0;
        #2;
        check("R5 ser_out cleared without clock", 32'(ser_out), 32'h0);
        check("R5 par_q untouched", 32'(par_q), 32'hC3);
        #2 shift_clr_n = 1'b1;
        #1 store_pulse();
        check("R5 chain was zeroed", 32'(par_q), 32'h0);

        // R6: latch clear leaves chain alone
        load_byte(8'h96);
        store_pulse();
        #1 store_clr_n = 1'b0;
        #2;
        check("R6 par_q cleared without clock", 32'(par_q), 32'h0);
        check("R7 ser_out unchanged by store clear", 32'(ser_out), 32'h1);
        #2 store_clr_n = 1'b1;
        #1 store_pulse();
        check("R6 chain untouched", 32'(par_q), 32'h96);

        // R2: falling shift edge does not sample
        ser_in = 1'b0;
        #HALF shift_clk = 1'b1;
        #1 ser_in = 1'b1;
        #HALF shift_clk = 1'b0;
        store_pulse();
        check("R2 falling shift edge ignored", 32'(par_q), 32'h2C);

        // R4: falling store edge does not sample
        #HALF store_clk = 1'b1;
        shift_bit(1'b1);
        #HALF store_clk = 1'b0;
        #1;
        check("R4 falling store edge ignored", 32'(par_q), 32'h2C);
        store_pulse();
        check("R3 next store picks up shift", 32'(par_q), 32'h59);

        // R8: tied clocks, one-pulse lag
        clear_both();
        m_sh = '0;
        m_par = '0;
        pat = 8'b1011_0010;
        for (int i = 0; i < 10; i++) begin
            logic b;
            b = pat[i % 8] ^ (i > 7);
            both_pulse(b);
            m_par = m_sh;
            m_sh = {m_sh[W-2:0], b};
            check("R8 tied clocks lag", 32'(par_q), 32'(m_par));
        end

        // R9: held clears dominate clock edges
        clear_both();
        shift_clr_n = 1'b0;
        store_clr_n = 1'b0;
        shift_bit(1'b1);
        shift_bit(1'b1);
        store_pulse();
        check("R9 store clear holds over edge", 32'(par_q), 32'h0);
        store_clr_n = 1'b1;
        #1 store_pulse();
        check("R9 shift clear held over edges", 32'(par_q), 32'h0);
        shift_clr_n = 1'b1;
        #1 shift_bit(1'b1);
        store_pulse();
        check("R9 first edge after release", 32'(par_q), 32'h01);

        // R10: two-block cascade
        clear_both();
        word = 16'hBEEF;
        for (int i = 15; i >= 0; i--) shift_bit(word[i]);
        store_pulse();
        check("R10 low block", 32'(par_q), 32'hEF);
        check("R10 high block", 32'(par_q2), 32'hBE);
        check("R10 cascade tail", 32'(ser_out2), 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule